// File: doc/BRIEF.md
# Interrupt Coalescing Controller

This block reduces the interrupt load on a host by gathering many per-packet completion pulses into a smaller number of final interrupts. It has two independent channels. The transmit channel accepts a vector of completion sources, six by default. The receive channel accepts a single completion source. Each channel holds a pending count and a pending age. It raises its final interrupt when either quantity reaches the limit programmed for it.

One 32-bit configuration word controls both channels. Each half holds an enable flag, a 7-bit count limit and an 8-bit age limit. The age is measured in ticks of 20 µs, and an internal prescaler derives that tick from the system clock. The final interrupts are held in a two-bit sticky status. The host clears a status bit by writing 1 to it. When coalescing is disabled for a channel, every completion pulse sets that channel's status bit directly.

Top module: `irq_coalesce_top`

## Requirements
- R1: The configuration word reads as zero after reset. A write stores the whole 32-bit value, which appears on `cfg_word` one cycle later. Without a write, the word holds its value.
- R2: The configuration word is laid out as follows. The transmit enable is bit 31, the transmit count limit is bits 30:24 and the transmit age limit is bits 23:16. The receive enable is bit 15, the receive count limit is bits 14:8 and the receive age limit is bits 7:0. Status bit 0 belongs to transmit and status bit 1 belongs to receive.
- R3: The prescaler produces a one-cycle tick once in every `TICK_DIV` clock cycles. The first tick falls on the `TICK_DIV`-th cycle after reset.
- R4: When a channel's enable bit is 0, any cycle with at least one completion pulse sets that channel's status bit at the next clock edge. No state is kept pending.
- R5: When a channel is enabled with a nonzero count limit, the channel fires in the cycle where the pending count, including this cycle's pulses, becomes greater than or equal to the limit. Transmit pulses arriving in the same cycle each add one to the count.
- R6: When a channel is enabled with a nonzero age limit, the age starts at zero when the first pulse becomes pending. The age then increases by one on each tick while pulses are pending. The channel fires in the cycle where the age is greater than or equal to the limit.
- R7: A count limit of zero turns off only the count check, and an age limit of zero turns off only the age check. When both limits are zero on an enabled channel, every cycle with a pulse fires at once.
- R8: Firing clears the pending count and the age. The pulses of the firing cycle are absorbed by that firing.
- R9: The pending count saturates at 127 and never wraps.
- R10: A status bit stays set until a clear write carries a 1 in its position. If the channel fires in the same cycle as the clear, the bit stays set.
- R11: The two channels share no state except the configuration word and the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration value to store |
| cfg_word | output | 32 | Current configuration word |
| tx_done | input | N_TX | Transmit completion pulses |
| rx_done | input | 1 | Receive completion pulse |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_data | input | 2 | Write-1-to-clear mask (bit 0 tx, bit 1 rx) |
| irq_sts | output | 2 | Final interrupt status (bit 0 tx, bit 1 rx) |

## Verification
On every cycle, the assertions check the following behaviours. A status bit falls only after a clear that names it, and it stays set otherwise. A pulse on a disabled channel or on a channel with both limits at zero sets its status at the next edge. A count limit of one fires on the first pulse. The configuration word stays stable without a write. Age-based firing depends on where the free-running tick falls, and the count saturates only after a long burst. Only the bench's cycle-by-cycle reference comparison can show these two behaviours. The bench sweeps the enable flag, count limits 0 to 4 and age limits 0 to 3 under dense and sparse traffic. It also runs a dedicated burst that drives the count into saturation.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
    localparam int CNT_W  = 7;
    localparam int AGE_W  = 8;
    localparam int WORD_W = 32;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cnt_lim;
        logic [AGE_W-1:0] age_lim;
    } chan_cfg_t;

    typedef struct packed {
        chan_cfg_t tx;
        chan_cfg_t rx;
    } coal_cfg_t;

    typedef enum logic [0:0] {
        CH_TX = 1'b0,
        CH_RX = 1'b1
    } chan_id_e;

    function automatic logic limits_off(input chan_cfg_t c);
        return (c.cnt_lim == '0) && (c.age_lim == '0);
    endfunction
endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
    parameter int TICK_DIV = 2000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

    generate
        if (TICK_DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            logic [DW-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst)                div_q <= '0;
                else if (div_q == LAST) div_q <= '0;
                else                    div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/irq_coal_channel.sv
module irq_coal_channel
    import irq_coal_pkg::*;
#(
    parameter int N_SRC = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  chan_cfg_t        cfg,
    input  logic             tick,
    input  logic [N_SRC-1:0] done,
    output logic             fire
);
    localparam int IW = $clog2(N_SRC + 1);
    localparam int SW = CNT_W + IW;

    logic [CNT_W-1:0] pend_q;
    logic [AGE_W-1:0] age_q;
    logic [IW-1:0]    inc;
    logic [SW-1:0]    sum;
    logic [CNT_W-1:0] next_cnt;
    logic             cnt_hit, age_hit, direct;

    always_comb begin
        inc = '0;
        for (int i = 0; i < N_SRC; i++) inc = inc + IW'(done[i]);
    end

    always_comb begin
        sum      = SW'(pend_q) + SW'(inc);
        next_cnt = (sum > SW'(CNT_MAX)) ? CNT_MAX : sum[CNT_W-1:0];
        cnt_hit  = (cfg.cnt_lim != '0) && (next_cnt >= cfg.cnt_lim);
        age_hit  = (cfg.age_lim != '0) && (pend_q != '0) && (age_q >= cfg.age_lim);
        direct   = (inc != '0) && (!cfg.en || limits_off(cfg));
        fire     = direct || (cfg.en && (cnt_hit || age_hit));
    end

    always_ff @(posedge clk) begin
        if (rst || fire || !cfg.en) begin
            pend_q <= '0;
            age_q  <= '0;
        end else begin
            pend_q <= next_cnt;
            if ((pend_q != '0) && tick && (age_q != AGE_MAX))
                age_q <= age_q + 1'b1;
        end
    end
endmodule

// File: rtl/irq_coalesce_top.sv
module irq_coalesce_top
    import irq_coal_pkg::*;
#(
    parameter int N_TX     = 6,
    parameter int TICK_DIV = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_word,
    input  logic [N_TX-1:0]   tx_done,
    input  logic              rx_done,
    input  logic              sts_clr_we,
    input  logic [1:0]        sts_clr_data,
    output logic [1:0]        irq_sts
);
    coal_cfg_t  cfg_q;
    logic       tick;
    logic [1:0] fire;
    logic [1:0] clr_mask;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_we) cfg_q <= coal_cfg_t'(cfg_wdata);
    end
    assign cfg_word = cfg_q;

    irq_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    irq_coal_channel #(.N_SRC(N_TX)) tx_ch_i (
        .clk (clk),
        .rst (rst),
        .cfg (cfg_q.tx),
        .tick(tick),
        .done(tx_done),
        .fire(fire[CH_TX])
    );

    irq_coal_channel #(.N_SRC(1)) rx_ch_i (
        .clk (clk),
        .rst (rst),
        .cfg (cfg_q.rx),
        .tick(tick),
        .done(rx_done),
        .fire(fire[CH_RX])
    );

    assign clr_mask = sts_clr_we ? sts_clr_data : 2'b00;

    always_ff @(posedge clk) begin
        if (rst) irq_sts <= '0;
        else     irq_sts <= (irq_sts & ~clr_mask) | fire;
    end
endmodule

// File: rtl/irq_coalesce_chk.sv
module irq_coalesce_chk #(
    parameter int N_TX = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic [31:0]      cfg_word,
    input logic [N_TX-1:0]  tx_done,
    input logic             rx_done,
    input logic             sts_clr_we,
    input logic [1:0]       sts_clr_data,
    input logic [1:0]       irq_sts
);
    // R1
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_word));

    // R10
    tx_fall_needs_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_sts[0]) |-> $past(sts_clr_we && sts_clr_data[0]));

    // R10
    rx_fall_needs_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_sts[1]) |-> $past(sts_clr_we && sts_clr_data[1]));

    // R10
    tx_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_sts[0] && !(sts_clr_we && sts_clr_data[0])) |=> irq_sts[0]);

    // R4
    tx_direct_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_word[31] && (tx_done != '0)) |=> irq_sts[0]);

    // R4
    rx_direct_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_word[15] && rx_done) |=> irq_sts[1]);

    // R7
    tx_both_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_word[31] && cfg_word[30:16] == '0 && (tx_done != '0)) |=> irq_sts[0]);

    // R5
    rx_cnt_one_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_word[15] && cfg_word[14:8] == 7'd1 && rx_done) |=> irq_sts[1]);
endmodule

bind irq_coalesce_top irq_coalesce_chk #(.N_TX(N_TX)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_word    (cfg_word),
    .tx_done     (tx_done),
    .rx_done     (rx_done),
    .sts_clr_we  (sts_clr_we),
    .sts_clr_data(sts_clr_data),
    .irq_sts     (irq_sts)
);

// File: tb/irq_coalesce_top_tb_top.sv
module irq_coalesce_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int N_TX       = 6;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_word;
    logic [N_TX-1:0] tx_done = '0;
    logic        rx_done = 1'b0;
    logic        sts_clr_we = 1'b0;
    logic [1:0]  sts_clr_data = '0;
    logic [1:0]  irq_sts;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    string cur_req = "R1";

    // reference state, built from the requirements
    int          mdiv;
    logic [31:0] mcfg;
    logic [1:0]  msts;
    int          mp [2];
    int          ma [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_coalesce_top #(.N_TX(N_TX), .TICK_DIV(TICK_DIV)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_word(cfg_word), .tx_done(tx_done), .rx_done(rx_done),
        .sts_clr_we(sts_clr_we), .sts_clr_data(sts_clr_data), .irq_sts(irq_sts)
    );

    always @(posedge clk) begin : model
        logic        tk;
        logic [15:0] half;
        logic        en;
        int          cl, tl, inc, sum;
        logic [1:0]  f, clr;
        if (rst) begin
            mdiv <= 0; mcfg <= '0; msts <= '0;
            mp[0] <= 0; mp[1] <= 0; ma[0] <= 0; ma[1] <= 0;
        end else begin
            // R3: tick once every TICK_DIV cycles
            tk = (mdiv == TICK_DIV - 1);
            mdiv <= tk ? 0 : mdiv + 1;
            for (int c = 0; c < 2; c++) begin
                // R2: tx in the upper half, rx in the lower half
                half = (c == 0) ? mcfg[31:16] : mcfg[15:0];
                en = half[15];
                cl = int'(half[14:8]);
                tl = int'(half[7:0]);
                inc = (c == 0) ? $countones(tx_done) : int'(rx_done);
                sum = mp[c] + inc;
                if (sum > 127) sum = 127;
                f[c] = (inc > 0 && (!en || (cl == 0 && tl == 0)))
                    || (en && cl != 0 && sum >= cl)
                    || (en && tl != 0 && mp[c] != 0 && ma[c] >= tl);
                if (f[c] || !en) begin
                    mp[c] <= 0; ma[c] <= 0;
                end else begin
                    mp[c] <= sum;
                    if (mp[c] != 0 && tk && ma[c] < 255) ma[c] <= ma[c] + 1;
                end
            end
            clr = sts_clr_we ? sts_clr_data : 2'b00;
            msts <= (msts & ~clr) | f;
            if (cfg_we) mcfg <= cfg_wdata;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            n_cmp++;
            if (irq_sts !== msts) begin
                n_bad++;
                $display("FAIL %s irq_sts actual=%b expected=%b cycle=%0d", cur_req, irq_sts, msts, cyc);
            end
            n_cmp++;
            if (cfg_word !== mcfg) begin
                n_bad++;
                $display("FAIL R1 R2 cfg_word actual=%h expected=%h", cfg_word, mcfg);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v; tx_done = '0; rx_done = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        logic [15:0] half;
        lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check_bit("R1 cfg zero", cfg_word == 32'h0, 1'b1);
        check_bit("R1 sts zero", irq_sts == 2'b00, 1'b1);

        for (int en = 0; en < 2; en++)
            for (int cl = 0; cl < 5; cl++)
                for (int tl = 0; tl < 4; tl++)
                    for (int dense = 0; dense < 2; dense++) begin
                        if (en == 0)                cur_req = "R4 R11";
                        else if (cl == 0 && tl == 0) cur_req = "R7";
                        else if (tl == 0)           cur_req = "R5 R8";
                        else if (cl == 0)           cur_req = "R6 R3";
                        else                        cur_req = "R5 R6 R7 R10";
                        half = {en[0], 7'(cl), 8'(tl)};
                        // rx gets a shifted copy of the settings so the halves differ
                        write_cfg({half, en[0], 7'((cl + 1) % 5), 8'((tl + 2) % 4)});
                        for (int k = 0; k < 40; k++) begin
                            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                            if (dense == 1) tx_done = lfsr[5:0] & lfsr[11:6];
                            else            tx_done = (lfsr[15:13] == 3'b000) ? lfsr[5:0] : '0;
                            rx_done = (dense == 1) ? lfsr[7] : (lfsr[15:12] == 4'h3);
                            sts_clr_we = (k % 7 == 6);
                            sts_clr_data = lfsr[9:8];
                            step();
                        end
                        tx_done = '0; rx_done = 1'b0; sts_clr_we = 1'b0;
                    end

        // R10: clear in the same cycle as a fire keeps the bit set
        cur_req = "R10";
        write_cfg(32'h0000_0000);
        tx_done = 6'b000001; sts_clr_we = 1'b1; sts_clr_data = 2'b01;
        step();
        tx_done = '0; sts_clr_we = 1'b0;
        check_bit("R10 set wins over clear", irq_sts[0], 1'b1);
        sts_clr_we = 1'b1; sts_clr_data = 2'b11;
        step();
        sts_clr_we = 1'b0;
        check_bit("R10 clear tx", irq_sts[0], 1'b0);
        check_bit("R10 clear rx", irq_sts[1], 1'b0);

        // R9: saturation, then raising the limit to 127 fires at once
        cur_req = "R9";
        write_cfg({1'b1, 7'd0, 8'd200, 16'h0000});
        for (int k = 0; k < 30; k++) begin
            tx_done = '1;
            step();
        end
        tx_done = '0;
        check_bit("R9 no fire without limit", irq_sts[0], 1'b0);
        write_cfg({1'b1, 7'd127, 8'd200, 16'h0000});
        check_bit("R9 limit just loaded", irq_sts[0], 1'b0);
        step();
        check_bit("R9 saturated count fires", irq_sts[0], 1'b1);

        // R5: six simultaneous pulses reach a count limit of 6 in one cycle
        cur_req = "R5";
        sts_clr_we = 1'b1; sts_clr_data = 2'b11;
        step();
        sts_clr_we = 1'b0;
        write_cfg({1'b1, 7'd6, 8'd0, 16'h0000});
        tx_done = '1;
        step();
        tx_done = '0;
        check_bit("R5 six pulses in one cycle", irq_sts[0], 1'b1);

        step();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule